// File: doc/BRIEF.md
# Transmit Sample Buffer with DMA Request

This block sits between a bus write port and an audio serializer on the playback path. Software or a DMA engine writes samples one at a time into a 64-entry first-in first-out store. The serializer takes a whole frame at a time, one sample for each active channel. A remap stage between the store and the serializer chooses which of the frame's samples drives each output slot. A DMA request is raised while the store has room for a full burst and requests are enabled.

A flush pulse empties the store in one cycle. A running counter adds up the samples the serializer has consumed, and software can clear it to zero. Two sticky flags record a write that arrived while the store was full and a frame request that found too few samples. The flush clears both flags.

Top module: `pcm_tx_buffer`

## Requirements
- R1: After reset the fill level, the consumed-sample count and both sticky flags are zero, every slot output is zero, and `dmaReq` equals `dreqEnable`.
- R2: Each cycle with `wrValid` high and the store not full appends `wrData`, which raises the level by one. Samples leave in the order they were written.
- R3: A write while the level is 64 is dropped. The level stays at 64, the stored data is unchanged, and `overflow` is set and stays set.
- R4: A `popFrame` pulse while the level is at least `chanCount`+1 removes `chanCount`+1 samples from the head and adds `chanCount`+1 to `sampleCount`.
- R5: A `popFrame` pulse while the level is below `chanCount`+1 removes nothing and leaves `sampleCount` unchanged. It sets `underrun`, which then stays set.
- R6: A `flushReq` pulse sets the level to zero on the next clock edge and clears both sticky flags. A write or pop in the same cycle is ignored, and `sampleCount` is kept.
- R7: A `cntClear` pulse sets `sampleCount` to zero on the next edge. It takes priority over a pop in the same cycle, although that pop still removes its samples.
- R8: `dmaReq` is high exactly when `dreqEnable` is high and the free space (64 minus the level) is at least 8. With the defaults this means a level of 56 or below.
- R9: Slot s (s = 0..7) is `slotData[16s+15:16s]`. It shows the sample at head offset k, where k is `chanMap[4s+3:4s]`, when s ≤ `chanCount`, k ≤ `chanCount` and k < level. Otherwise the slot shows zero. The map value 0x76543210 is the identity mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Bus write strobe for the sample data port |
| wrData | input | 16 | Sample written by the bus |
| flushReq | input | 1 | One-cycle flush pulse |
| cntClear | input | 1 | One-cycle clear of the consumed-sample counter |
| dreqEnable | input | 1 | Allows the DMA request output |
| chanCount | input | 3 | Number of active channels minus one |
| chanMap | input | 32 | Slot remap, 4 bits per slot, slot s at bits 4s+3:4s |
| popFrame | input | 1 | Serializer takes one frame |
| slotData | output | 128 | Mapped sample per slot, slot s at bits 16s+15:16s |
| dmaReq | output | 1 | DMA request: room for a burst of 8 |
| sampleCount | output | 32 | Running count of consumed samples |
| fifoLevel | output | 7 | Number of stored samples, 0 to 64 |
| overflow | output | 1 | Sticky: a write was dropped while full |
| underrun | output | 1 | Sticky: a frame pop found too few samples |

## Verification
The bench fills the store to exactly 64, sends one more write, and then drains it. A design that stored the extra sample or corrupted the tail would show the wrong value in the last frame's top slot. It moves the level across 56 and 57 to catch an off-by-one in the burst threshold. It pops a frame that is larger than the remaining level, and a design that popped partially would show a drop in the level or a changed count. It issues a flush while also writing, and a counter clear while also popping, to expose the wrong priority. It uses a reversed map and an index beyond the active channel count, which exposes a remap that reads the wrong head offset or shows stale data instead of zero.

// File: rtl/pcmtx_pkg.sv
package pcmtx_pkg;
  localparam int SLOTS       = 8;
  localparam int SLOT_W      = $clog2(SLOTS);
  localparam int MAP_FIELD_W = 4;
  localparam int FRAME_W     = SLOT_W + 1;

  typedef struct packed {
    logic               doWrite;
    logic               doPop;
    logic               doFlush;
    logic [FRAME_W-1:0] popCount;
  } dp_strobe_t;
endpackage

// File: rtl/pcmtx_datapath.sv
module pcmtx_datapath
  import pcmtx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 64,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dp_strobe_t                  strb,
  input  logic [SAMPLE_W-1:0]         wrData,
  input  logic [SLOT_W-1:0]           chanCount,
  input  logic [SLOTS*MAP_FIELD_W-1:0] chanMap,
  output logic [LVL_W-1:0]            level,
  output logic [SLOTS*SAMPLE_W-1:0]   slotData
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    if (strb.doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.doFlush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.doWrite) wrPtr <= wrPtr + 1'b1;
      if (strb.doPop)   rdPtr <= rdPtr + PTR_W'(strb.popCount);
      level <= level + LVL_W'(strb.doWrite)
                     - (strb.doPop ? LVL_W'(strb.popCount) : '0);
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [MAP_FIELD_W-1:0] idx;
    logic                   inUse;
    logic [PTR_W-1:0]       addr;
    always_comb begin
      idx   = chanMap[s*MAP_FIELD_W +: MAP_FIELD_W];
      addr  = rdPtr + PTR_W'(idx);
      inUse = (SLOT_W'(s) <= chanCount)
           && (idx <= MAP_FIELD_W'(chanCount))
           && (LVL_W'(idx) < level);
      slotData[s*SAMPLE_W +: SAMPLE_W] = inUse ? mem[addr] : '0;
    end
  end

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFlush |=> level == '0);

  // R4
  pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doPop && !strb.doWrite && !strb.doFlush)
      |=> level == $past(level) - LVL_W'($past(strb.popCount)));
endmodule

// File: rtl/pcmtx_ctrl.sv
module pcmtx_ctrl
  import pcmtx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int BURST  = 8,
  parameter int CNT_W  = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              popFrame,
  input  logic              flushReq,
  input  logic              cntClear,
  input  logic              dreqEnable,
  input  logic [SLOT_W-1:0] chanCount,
  input  logic [LVL_W-1:0]  level,
  output dp_strobe_t        strb,
  output logic              dmaReq,
  output logic [CNT_W-1:0]  sampleCount,
  output logic              overflow,
  output logic              underrun
);
  logic [FRAME_W-1:0] frameSize;
  logic               isFull;
  logic               canPop;
  logic [LVL_W-1:0]   freeSpace;

  always_comb begin
    frameSize     = FRAME_W'(chanCount) + 1'b1;
    isFull        = (level == LVL_W'(DEPTH));
    canPop        = (level >= LVL_W'(frameSize));
    freeSpace     = LVL_W'(DEPTH) - level;
    strb.doFlush  = flushReq;
    strb.doWrite  = wrValid && !isFull && !flushReq;
    strb.doPop    = popFrame && canPop && !flushReq;
    strb.popCount = frameSize;
    dmaReq        = dreqEnable && (freeSpace >= LVL_W'(BURST));
  end

  always_ff @(posedge clk) begin
    if (!rstN || cntClear) sampleCount <= '0;
    else if (strb.doPop)   sampleCount <= sampleCount + CNT_W'(frameSize);
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushReq) begin
      overflow <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (wrValid && isFull)   overflow <= 1'b1;
      if (popFrame && !canPop) underrun <= 1'b1;
    end
  end

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !flushReq) |=> overflow);

  // R7
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> sampleCount == '0);

  // R5
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popFrame && !flushReq && (level < LVL_W'(frameSize))) |=> underrun);

  // R8
  full_noreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_W'(DEPTH)) |-> !dmaReq);
endmodule

// File: rtl/pcm_tx_buffer.sv
module pcm_tx_buffer
  import pcmtx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 64,
  parameter int BURST    = 8,
  parameter int CNT_W    = 32,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrValid,
  input  logic [SAMPLE_W-1:0]          wrData,
  input  logic                         flushReq,
  input  logic                         cntClear,
  input  logic                         dreqEnable,
  input  logic [SLOT_W-1:0]            chanCount,
  input  logic [SLOTS*MAP_FIELD_W-1:0] chanMap,
  input  logic                         popFrame,
  output logic [SLOTS*SAMPLE_W-1:0]    slotData,
  output logic                         dmaReq,
  output logic [CNT_W-1:0]             sampleCount,
  output logic [LVL_W-1:0]             fifoLevel,
  output logic                         overflow,
  output logic                         underrun
);
  dp_strobe_t strb;

  pcmtx_ctrl #(.DEPTH(DEPTH), .BURST(BURST), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .popFrame(popFrame),
    .flushReq(flushReq), .cntClear(cntClear), .dreqEnable(dreqEnable),
    .chanCount(chanCount), .level(fifoLevel), .strb(strb), .dmaReq(dmaReq),
    .sampleCount(sampleCount), .overflow(overflow), .underrun(underrun)
  );

  pcmtx_datapath #(.SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .chanCount(chanCount), .chanMap(chanMap), .level(fifoLevel),
    .slotData(slotData)
  );
endmodule

// File: tb/sim_pcm_tx_buffer.sv
module sim_pcm_tx_buffer;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic [15:0]  wrData = '0;
  logic         flushReq = 1'b0;
  logic         cntClear = 1'b0;
  logic         dreqEnable = 1'b0;
  logic [2:0]   chanCount = 3'd1;
  logic [31:0]  chanMap = 32'h7654_3210;
  logic         popFrame = 1'b0;
  logic [127:0] slotData;
  logic         dmaReq;
  logic [31:0]  sampleCount;
  logic [6:0]   fifoLevel;
  logic         overflow;
  logic         underrun;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] expCount = '0;

  always #2 clk = ~clk;

  pcm_tx_buffer u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .flushReq(flushReq), .cntClear(cntClear), .dreqEnable(dreqEnable),
    .chanCount(chanCount), .chanMap(chanMap), .popFrame(popFrame),
    .slotData(slotData), .dmaReq(dmaReq), .sampleCount(sampleCount),
    .fifoLevel(fifoLevel), .overflow(overflow), .underrun(underrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] slot(input int s);
    return slotData[s*16 +: 16];
  endfunction

  task automatic step();
    @(negedge clk);
    wrValid = 1'b0; flushReq = 1'b0; cntClear = 1'b0; popFrame = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    wrValid = 1'b1; wrData = d; step();
  endtask

  task automatic pop();
    popFrame = 1'b1; step();
  endtask

  task automatic doFlush();
    flushReq = 1'b1; step();
  endtask

  task automatic testReset();
    chk("R1 level", 32'(fifoLevel), 0);
    chk("R1 count", sampleCount, 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 underrun", 32'(underrun), 0);
    chk("R1 slot0", 32'(slot(0)), 0);
    chk("R1 dmaReq off", 32'(dmaReq), 0);
    dreqEnable = 1'b1; #1;
    chk("R1 dmaReq on", 32'(dmaReq), 1);
  endtask

  task automatic testOrderAndUnderrun();
    chanCount = 3'd1; chanMap = 32'h7654_3210;
    push(16'h1111); push(16'h2222); push(16'h3333);
    chk("R2 level", 32'(fifoLevel), 3);
    chk("R9 slot0", 32'(slot(0)), 32'h1111);
    chk("R9 slot1", 32'(slot(1)), 32'h2222);
    chk("R9 slot2 inactive", 32'(slot(2)), 0);
    pop(); expCount += 2;
    chk("R4 level", 32'(fifoLevel), 1);
    chk("R4 count", sampleCount, expCount);
    chk("R2 next head", 32'(slot(0)), 32'h3333);
    chk("R9 slot1 beyond level", 32'(slot(1)), 0);
    pop();
    chk("R5 underrun", 32'(underrun), 1);
    chk("R5 level kept", 32'(fifoLevel), 1);
    chk("R5 count kept", sampleCount, expCount);
    step();
    chk("R5 sticky", 32'(underrun), 1);
  endtask

  task automatic testFlush();
    wrValid = 1'b1; wrData = 16'hBEEF; popFrame = 1'b1; flushReq = 1'b1; step();
    chk("R6 level", 32'(fifoLevel), 0);
    chk("R6 underrun cleared", 32'(underrun), 0);
    chk("R6 count kept", sampleCount, expCount);
    chk("R6 slot0", 32'(slot(0)), 0);
  endtask

  task automatic testClear();
    push(16'h0A0A); push(16'h0B0B);
    popFrame = 1'b1; cntClear = 1'b1; step();
    expCount = 0;
    chk("R7 count", sampleCount, 0);
    chk("R7 pop still happens", 32'(fifoLevel), 0);
  endtask

  task automatic testMap();
    chanCount = 3'd3; chanMap = 32'h7654_0123;
    for (int i = 0; i < 4; i++) push(16'hA000 + 16'(i));
    chk("R9 reversed slot0", 32'(slot(0)), 32'hA003);
    chk("R9 reversed slot3", 32'(slot(3)), 32'hA000);
    chanMap = 32'h7654_0125; #1;
    chk("R9 index beyond channels", 32'(slot(0)), 0);
    chk("R9 slot1 still mapped", 32'(slot(1)), 32'hA002);
    pop(); expCount += 4;
    chk("R4 four-channel count", sampleCount, expCount);
    chk("R4 four-channel level", 32'(fifoLevel), 0);
    chanMap = 32'h7654_3210;
  endtask

  task automatic testDreq();
    for (int i = 0; i < 56; i++) push(16'(i));
    chk("R8 level 56 request", 32'(dmaReq), 1);
    push(16'h0038);
    chk("R8 level 57 no request", 32'(dmaReq), 0);
    doFlush();
    chk("R8 empty request", 32'(dmaReq), 1);
    dreqEnable = 1'b0; #1;
    chk("R8 disabled", 32'(dmaReq), 0);
    dreqEnable = 1'b1;
  endtask

  task automatic testOverflow();
    chanCount = 3'd7;
    for (int i = 0; i < 64; i++) push(16'h5000 + 16'(i));
    chk("R3 full level", 32'(fifoLevel), 64);
    chk("R3 no flag yet", 32'(overflow), 0);
    push(16'hDEAD);
    chk("R3 level held", 32'(fifoLevel), 64);
    chk("R3 overflow", 32'(overflow), 1);
    chk("R2 first out", 32'(slot(0)), 32'h5000);
    for (int f = 0; f < 7; f++) begin
      pop(); expCount += 8;
    end
    chk("R3 last frame slot7", 32'(slot(7)), 32'h503F);
    chk("R3 last frame slot0", 32'(slot(0)), 32'h5038);
    pop(); expCount += 8;
    chk("R3 drained", 32'(fifoLevel), 0);
    chk("R4 count after drain", sampleCount, expCount);
    chk("R3 sticky", 32'(overflow), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testOrderAndUnderrun();
        testFlush();
        testClear();
        testMap();
        testDreq();
        testOverflow();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nErrors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule